// File: doc/BRIEF.md
# Predictive Dead-Time Gate Sequencer

This block turns one PWM command into the two gate-drive enables of a synchronous buck stage. The high-side enable follows the command high and the low-side enable follows it low. Both enables stay off for a dead time at every edge. Each edge has its own turn-on delay, stored as a code that counts clock ticks. The code is meant to run at one tick per 4 ns step. Turn-off has no adjustable part: a gate drops a fixed number of cycles after the command changes.

The block settles each delay from what happened in the previous switching cycle. It does not react during the current edge. While both gates are off, it watches a digitized body-diode comparator. It keeps a record of whether conduction appeared during that window. When the window ends, it moves the delay code of the gate that is turning on by one step. If conduction was seen, the code gets shorter. If none was seen, the code gets longer to probe for the boundary. The loop keeps no safety margin, so in steady state the code moves back and forth across the cross-conduction boundary. Both inputs pass through two-flop synchronizers. That latency is part of the fixed turn-off delay.

Top module: `pdt_ctrl`

## Requirements
- R1: While reset is asserted, both gate enables are 0 and both delay codes read CODE_MAX.
- R2: A gate enable falls exactly 3 clock cycles after the PWM input changes level: two synchronizer stages plus one register. This holds whatever the delay codes are.
- R3: The dead time is the number of clock cycles with both enables at 0 before a gate turns on. It equals the delay code of that gate as seen on its port, an unsigned count of ticks. The code is g1_delay before g1_en rises and g2_delay before g2_en rises.
- R4: When a dead-time window completes, the delay code of the gate turning on decreases by one if the synchronized diode input was 1 in any cycle of that window. Otherwise it increases by one. The new value appears in the same cycle the gate turns on and sets the next window for that edge.
- R5: A delay code never goes below CODE_MIN or above CODE_MAX. An update that would cross a limit leaves the code at that limit.
- R6: The two loops are independent. A window before g1_en rises changes only g1_delay, and a window before g2_en rises changes only g2_delay.
- R7: g1_en and g2_en are never 1 in the same cycle. A rising enable always follows a cycle with the other enable at 0.
- R8: If the PWM input returns to its previous level before a dead-time window completes, the pending gate never turns on and its code is left unchanged. The block then runs the opposite window in full, and that window updates the other gate's code.
- R9: Against a fixed boundary B, a model comparator reports conduction whenever the active code is above B. Each code then settles within the two values B and B+1.
- R10: The diode input is counted only inside the dead-time window. Diode activity that ends before the window starts does not count as conduction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one tick is one delay step |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_cmd | input | 1 | PWM command, 1 selects the high-side gate |
| diode_cmp | input | 1 | Digitized body-diode conduction comparator |
| g1_en | output | 1 | High-side gate enable |
| g2_en | output | 1 | Low-side gate enable |
| g1_delay | output | CODE_W | Current high-side turn-on delay code |
| g2_delay | output | CODE_W | Current low-side turn-on delay code |

## Verification
The bench builds the block with a 5-bit code, CODE_MIN of 2 and CODE_MAX of 12. With these values a few switching cycles drive a code onto either limit, so saturation at both ends is easy to reach. The same values leave room for a model boundary of 6 inside the range, where the dithering loop can be watched. The narrow range also keeps each dead time short enough to run a glitch shorter than the window against a delay of at least three ticks.

// File: rtl/pdt_pkg.sv
package pdt_pkg;

    typedef enum logic [1:0] {
        PH_HI_ON = 2'd0,
        PH_DT_LO = 2'd1,
        PH_LO_ON = 2'd2,
        PH_DT_HI = 2'd3
    } phase_e;

    localparam int unsigned LOOP_HI = 0;
    localparam int unsigned LOOP_LO = 1;
    localparam int unsigned N_LOOPS = 2;

endpackage

// File: rtl/pdt_sync.sv
module pdt_sync #(
    parameter int unsigned W      = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stage_q [STAGES];
    logic [W-1:0] stage_d [STAGES];

    always_comb begin
        stage_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= stage_d[i];
            end
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/pdt_loop.sv
module pdt_loop #(
    parameter int unsigned CODE_W   = 5,
    parameter int unsigned CODE_MIN = 1,
    parameter int unsigned CODE_MAX = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  logic              seen,
    output logic [CODE_W-1:0] code
);

    localparam logic [CODE_W-1:0] LIM_LO = CODE_W'(CODE_MIN);
    localparam logic [CODE_W-1:0] LIM_HI = CODE_W'(CODE_MAX);
    localparam logic [CODE_W-1:0] ONE    = CODE_W'(1);

    logic [CODE_W-1:0] code_d, code_q;

    always_comb begin
        code_d = code_q;
        if (upd) begin
            if (seen) begin
                code_d = (code_q > LIM_LO) ? code_q - ONE : LIM_LO;
            end else begin
                code_d = (code_q < LIM_HI) ? code_q + ONE : LIM_HI;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= LIM_HI;
        end else begin
            code_q <= code_d;
        end
    end

    assign code = code_q;

endmodule

// File: rtl/pdt_seq.sv
module pdt_seq
    import pdt_pkg::*;
#(
    parameter int unsigned CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwm_s,
    input  logic              diode_s,
    input  logic [CODE_W-1:0] code_hi,
    input  logic [CODE_W-1:0] code_lo,
    output logic              g1,
    output logic              g2,
    output logic              upd_hi,
    output logic              upd_lo,
    output logic              seen
);

    localparam logic [CODE_W-1:0] ONE = CODE_W'(1);

    typedef struct packed {
        phase_e            phase;
        logic [CODE_W-1:0] cnt;
        logic              flag;
        logic              g1;
        logic              g2;
    } seq_t;

    seq_t cur_q, nxt_d;

    always_comb begin
        nxt_d  = cur_q;
        upd_hi = 1'b0;
        upd_lo = 1'b0;
        seen   = cur_q.flag | diode_s;
        unique case (cur_q.phase)
            PH_HI_ON: begin
                if (!pwm_s) begin
                    nxt_d.phase = PH_DT_LO;
                    nxt_d.cnt   = '0;
                    nxt_d.flag  = 1'b0;
                end
            end
            PH_LO_ON: begin
                if (pwm_s) begin
                    nxt_d.phase = PH_DT_HI;
                    nxt_d.cnt   = '0;
                    nxt_d.flag  = 1'b0;
                end
            end
            PH_DT_LO: begin
                if (pwm_s) begin
                    nxt_d.phase = PH_DT_HI;
                    nxt_d.cnt   = '0;
                    nxt_d.flag  = 1'b0;
                end else if (cur_q.cnt == code_lo - ONE) begin
                    nxt_d.phase = PH_LO_ON;
                    upd_lo      = 1'b1;
                end else begin
                    nxt_d.cnt  = cur_q.cnt + ONE;
                    nxt_d.flag = seen;
                end
            end
            PH_DT_HI: begin
                if (!pwm_s) begin
                    nxt_d.phase = PH_DT_LO;
                    nxt_d.cnt   = '0;
                    nxt_d.flag  = 1'b0;
                end else if (cur_q.cnt == code_hi - ONE) begin
                    nxt_d.phase = PH_HI_ON;
                    upd_hi      = 1'b1;
                end else begin
                    nxt_d.cnt  = cur_q.cnt + ONE;
                    nxt_d.flag = seen;
                end
            end
            default: nxt_d.phase = PH_DT_LO;
        endcase
        nxt_d.g1 = (nxt_d.phase == PH_HI_ON);
        nxt_d.g2 = (nxt_d.phase == PH_LO_ON);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.phase <= PH_DT_LO;
            cur_q.cnt   <= '0;
            cur_q.flag  <= 1'b0;
            cur_q.g1    <= 1'b0;
            cur_q.g2    <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign g1 = cur_q.g1;
    assign g2 = cur_q.g2;

endmodule

// File: rtl/pdt_ctrl.sv
module pdt_ctrl
    import pdt_pkg::*;
#(
    parameter int unsigned CODE_W      = 5,
    parameter int unsigned CODE_MIN    = 1,
    parameter int unsigned CODE_MAX    = 31,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwm_cmd,
    input  logic              diode_cmp,
    output logic              g1_en,
    output logic              g2_en,
    output logic [CODE_W-1:0] g1_delay,
    output logic [CODE_W-1:0] g2_delay
);

    logic [1:0]        raw_in;
    logic [1:0]        sync_out;
    logic              upd_hi, upd_lo, seen;
    logic [N_LOOPS-1:0] upd_vec;
    logic [CODE_W-1:0] code_arr [N_LOOPS];

    assign raw_in = {diode_cmp, pwm_cmd};

    pdt_sync #(
        .W      (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_in),
        .dout  (sync_out)
    );

    pdt_seq #(
        .CODE_W (CODE_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .pwm_s   (sync_out[0]),
        .diode_s (sync_out[1]),
        .code_hi (code_arr[LOOP_HI]),
        .code_lo (code_arr[LOOP_LO]),
        .g1      (g1_en),
        .g2      (g2_en),
        .upd_hi  (upd_hi),
        .upd_lo  (upd_lo),
        .seen    (seen)
    );

    always_comb begin
        upd_vec          = '0;
        upd_vec[LOOP_HI] = upd_hi;
        upd_vec[LOOP_LO] = upd_lo;
    end

    for (genvar i = 0; i < N_LOOPS; i++) begin : g_loop
        pdt_loop #(
            .CODE_W   (CODE_W),
            .CODE_MIN (CODE_MIN),
            .CODE_MAX (CODE_MAX)
        ) u_loop (
            .clk   (clk),
            .rst_n (rst_n),
            .upd   (upd_vec[i]),
            .seen  (seen),
            .code  (code_arr[i])
        );
    end

    assign g1_delay = code_arr[LOOP_HI];
    assign g2_delay = code_arr[LOOP_LO];

endmodule

// File: rtl/pdt_ctrl_chk.sv
module pdt_ctrl_chk #(
    parameter int unsigned CODE_W   = 5,
    parameter int unsigned CODE_MIN = 1,
    parameter int unsigned CODE_MAX = 31
) (
    input logic              clk,
    input logic              rst_n,
    input logic              g1_en,
    input logic              g2_en,
    input logic [CODE_W-1:0] g1_delay,
    input logic [CODE_W-1:0] g2_delay
);

    localparam logic [CODE_W-1:0] ONE = CODE_W'(1);

    // R7
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(g1_en && g2_en));

    // R7
    g1_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(g1_en) |-> !$past(g2_en));

    // R7
    g2_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(g2_en) |-> !$past(g1_en));

    // R5
    hi_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (g1_delay >= CODE_W'(CODE_MIN)) && (g1_delay <= CODE_W'(CODE_MAX)));

    // R5
    lo_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (g2_delay >= CODE_W'(CODE_MIN)) && (g2_delay <= CODE_W'(CODE_MAX)));

    // R4
    hi_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(g1_delay) || (g1_delay == $past(g1_delay) + ONE)
                          || (g1_delay + ONE == $past(g1_delay)));

    // R4
    lo_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(g2_delay) || (g2_delay == $past(g2_delay) + ONE)
                          || (g2_delay + ONE == $past(g2_delay)));

    // R6
    hi_only_on_g1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(g1_delay) |-> $rose(g1_en));

    // R6
    lo_only_on_g2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(g2_delay) |-> $rose(g2_en));

endmodule

bind pdt_ctrl pdt_ctrl_chk #(
    .CODE_W   (CODE_W),
    .CODE_MIN (CODE_MIN),
    .CODE_MAX (CODE_MAX)
) u_pdt_ctrl_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .g1_en    (g1_en),
    .g2_en    (g2_en),
    .g1_delay (g1_delay),
    .g2_delay (g2_delay)
);

// File: tb/test_pdt_ctrl.sv
`timescale 1ns/1ps
module test_pdt_ctrl;

    localparam int unsigned CODE_W   = 5;
    localparam int unsigned CODE_MIN = 2;
    localparam int unsigned CODE_MAX = 12;
    localparam int          BOUND    = 6;
    localparam int          N_VEC    = 10;

    typedef struct packed {
        logic       pwm;
        logic       dio;
        logic [7:0] dead;
        logic [7:0] hi;
        logic [7:0] lo;
    } vec_t;

    localparam vec_t VECS [N_VEC] = '{
        '{1'b1, 1'b1, 8'd12, 8'd11, 8'd12},
        '{1'b0, 1'b1, 8'd12, 8'd11, 8'd11},
        '{1'b1, 1'b0, 8'd11, 8'd12, 8'd11},
        '{1'b0, 1'b0, 8'd11, 8'd12, 8'd12},
        '{1'b1, 1'b0, 8'd12, 8'd12, 8'd12},
        '{1'b0, 1'b1, 8'd12, 8'd12, 8'd11},
        '{1'b1, 1'b1, 8'd12, 8'd11, 8'd11},
        '{1'b0, 1'b1, 8'd11, 8'd11, 8'd10},
        '{1'b1, 1'b1, 8'd11, 8'd10, 8'd10},
        '{1'b0, 1'b0, 8'd10, 8'd10, 8'd11}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pwm_cmd = 1'b0;
    logic              diode_cmp = 1'b0;
    logic              g1_en, g2_en;
    logic [CODE_W-1:0] g1_delay, g2_delay;

    int checks = 0;
    int fails = 0;
    int overlaps = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    pdt_ctrl #(
        .CODE_W   (CODE_W),
        .CODE_MIN (CODE_MIN),
        .CODE_MAX (CODE_MAX)
    ) i_pdt_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwm_cmd   (pwm_cmd),
        .diode_cmp (diode_cmp),
        .g1_en     (g1_en),
        .g2_en     (g2_en),
        .g1_delay  (g1_delay),
        .g2_delay  (g2_delay)
    );

    always @(negedge clk) begin
        if (rst_n && g1_en && g2_en) overlaps++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Drive one command edge; diode level d_pre is held before the edge,
    // d_post from the edge on. Returns turn-off latency and dead time.
    task automatic step(input logic lvl, input logic d_pre, input logic d_post,
                        output int off_lat, output int dead);
        diode_cmp = d_pre;
        repeat (4) @(negedge clk);
        pwm_cmd   = lvl;
        diode_cmp = d_post;
        off_lat = 0;
        for (int k = 1; k < 60; k++) begin
            @(negedge clk);
            if ((lvl ? g2_en : g1_en) == 1'b0) begin
                off_lat = k;
                break;
            end
        end
        dead = 0;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            dead++;
            if ((lvl ? g1_en : g2_en) == 1'b1) break;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        int off_lat;
        int dead;
        int n;
        bit g1_seen;

        // R1 reset state
        repeat (3) @(negedge clk);
        check(!g1_en && !g2_en, "R1 gates off in reset", {g1_en, g2_en}, 0);
        check(g1_delay == CODE_MAX, "R1 g1_delay reset", g1_delay, CODE_MAX);
        check(g2_delay == CODE_MAX, "R1 g2_delay reset", g2_delay, CODE_MAX);
        rst_n = 1'b1;

        // R3 first low-side window after reset
        n = 0;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            n++;
            if (g2_en) break;
        end
        check(n == CODE_MAX, "R3 first dead time", n, CODE_MAX);
        check(g2_delay == CODE_MAX, "R5 max saturation after start", g2_delay, CODE_MAX);

        // Vector table: R2, R3, R4, R5, R6
        for (int v = 0; v < N_VEC; v++) begin
            step(VECS[v].pwm, VECS[v].dio, VECS[v].dio, off_lat, dead);
            check(off_lat == 3, "R2 turn-off latency", off_lat, 3);
            check(dead == int'(VECS[v].dead), "R3 dead time", dead, int'(VECS[v].dead));
            check(g1_delay == VECS[v].hi[CODE_W-1:0], "R4 R6 g1_delay", g1_delay, int'(VECS[v].hi));
            check(g2_delay == VECS[v].lo[CODE_W-1:0], "R4 R6 g2_delay", g2_delay, int'(VECS[v].lo));
        end

        // R8 aborted high-side window: hi=10, lo=11, low side on
        diode_cmp = 1'b0;
        repeat (4) @(negedge clk);
        pwm_cmd = 1'b1;
        repeat (3) @(negedge clk);
        pwm_cmd = 1'b0;
        g1_seen = 1'b0;
        n = 0;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            n++;
            if (g1_en) g1_seen = 1'b1;
            if (g2_en) break;
        end
        check(!g1_seen, "R8 g1 stays off", g1_seen, 0);
        check(n == 14, "R8 full low window after abort", n, 14);
        check(g1_delay == 10, "R8 g1_delay unchanged", g1_delay, 10);
        check(g2_delay == 12, "R8 g2_delay updated", g2_delay, 12);

        // R10 diode active only before the window: counts as no conduction
        step(1'b1, 1'b1, 1'b0, off_lat, dead);
        check(dead == 10, "R10 dead time", dead, 10);
        check(g1_delay == 11, "R10 g1_delay lengthened", g1_delay, 11);

        // R5 minimum saturation
        for (int s = 0; s < 24; s++) begin
            step((s % 2) == 0 ? 1'b0 : 1'b1, 1'b1, 1'b1, off_lat, dead);
        end
        check(g1_delay == CODE_MIN, "R5 g1_delay at min", g1_delay, CODE_MIN);
        check(g2_delay == CODE_MIN, "R5 g2_delay at min", g2_delay, CODE_MIN);
        check(dead == CODE_MIN, "R5 dead time at min", dead, CODE_MIN);
        check(off_lat == 3, "R2 latency at min code", off_lat, 3);

        // R9 dithering against a fixed model boundary
        for (int s = 0; s < 40; s++) begin
            logic lvl;
            logic d;
            lvl = ((s % 2) == 0) ? 1'b0 : 1'b1;
            d = lvl ? (int'(g1_delay) > BOUND) : (int'(g2_delay) > BOUND);
            step(lvl, d, d, off_lat, dead);
            if (s >= 30) begin
                check((dead == BOUND) || (dead == BOUND + 1), "R9 dead time in window", dead, BOUND);
                check((g1_delay == BOUND) || (g1_delay == BOUND + 1), "R9 g1_delay in window", g1_delay, BOUND);
                check((g2_delay == BOUND) || (g2_delay == BOUND + 1), "R9 g2_delay in window", g2_delay, BOUND);
            end
        end

        // R7 no overlap over the whole run
        check(overlaps == 0, "R7 no overlap", overlaps, 0);

        // R1 reset again mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(!g1_en && !g2_en, "R1 gates off on reset", {g1_en, g2_en}, 0);
        check(g1_delay == CODE_MAX && g2_delay == CODE_MAX, "R1 codes reset", g1_delay, CODE_MAX);

        finish_run();
    end

endmodule